// File: doc/BRIEF.md
# I2C Bus Address Scanner

This controller walks the whole raw I2C address byte range and reports every byte value that a device on the bus acknowledges. Each value is a 7-bit device address with the direction bit appended. A one-cycle start request begins a scan. The scanner then sends a short command sequence to a byte-level bus master that sits beside it. For every candidate it sends a START, writes the candidate as the address byte and looks at the acknowledge. It then ends the transaction with a STOP, whether or not the candidate was acknowledged.

A read address that is acknowledged needs extra handling. A device that sees its read address drives data onto the bus at once. The scanner therefore fetches one byte from that device and answers it with a NACK before it issues the STOP. Without this dummy read the device would still hold the data line, the STOP would fail, and the next address would show a false hit. With the dummy read, back-to-back scans give the same list.

Every hit appears as a one-cycle strobe carrying the raw byte value. For a device at 7-bit address 0x68, a write-capable and readable device produces 0xD0 and then 0xD1. A one-cycle done flag marks the end of a scan.

Top module: `i2c_addr_scanner`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o`, `found_valid_o` and `done_o` are all 0 until a start request arrives.
- R2: Commands to the bus master use the 2-bit code on `cmd_op_o`: 00 = START, 01 = WRITE byte, 10 = READ one byte and answer it with NACK, 11 = STOP. Each probe opens with START followed immediately by one WRITE.
- R3: Probes run in ascending raw address order from 0x00 to 0xFF. The byte sent with each WRITE on `cmd_byte_o` is the raw address being probed.
- R4: When a WRITE to an odd raw address (bit 0 = 1, a read address) is acknowledged, the next command is a READ. No READ follows an even address, and no READ follows an unacknowledged address.
- R5: Every probe ends with a STOP, whether or not it was acknowledged, before the next START is sent.
- R6: Every acknowledged raw address raises `found_valid_o` for exactly one clock, with `found_addr_o` equal to that address. Unacknowledged addresses produce no strobe.
- R7: After the STOP of address 0xFF completes, `done_o` is high for exactly one clock. During that clock `busy_o` is already 0, and no further command follows.
- R8: A start request that arrives while a scan is running has no effect. The running scan continues without a restart.
- R9: Two scans of an unchanged bus report identical lists of found addresses.
- R10: At most one command is outstanding. No new `cmd_valid_o` is raised before `rsp_valid_i` has answered the previous one, and commands appear only while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a scan |
| busy_o | output | 1 | High while a scan is running |
| cmd_valid_o | output | 1 | One-cycle strobe issuing a command to the bus master |
| cmd_op_o | output | 2 | Command code (00 START, 01 WRITE, 10 READ with NACK, 11 STOP) |
| cmd_byte_o | output | 8 | Raw address byte for WRITE commands |
| rsp_valid_i | input | 1 | One-cycle strobe from the bus master: the command has completed |
| rsp_ack_i | input | 1 | With `rsp_valid_i` after a WRITE: 1 if the slave acknowledged |
| found_valid_o | output | 1 | One-cycle strobe for an acknowledged address |
| found_addr_o | output | 8 | Raw address that was acknowledged |
| done_o | output | 1 | One-cycle strobe at the end of a scan |

## Verification
The bench builds the scanner with its default parameters: the full 0x00 to 0xFF range and the dummy-read variant switched on. This makes the real endpoints reachable. At 0x00 only a write is acknowledged, and at 0xFF a read hit has to finish its dummy read before done can appear. Because the range is not shortened, the step from the last address to done is checked on the real boundary.

The bus model responds after a random delay. After an acknowledged read address it keeps driving the bus until a READ arrives, so a missing dummy read shows up as a wrong command and a false hit. Between these directed devices the bench also places write-only, read-only and dual-direction devices, chosen from a fixed seed.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_START     = 2'b00,
      OP_WRITE     = 2'b01,
      OP_READ_NACK = 2'b10,
      OP_STOP      = 2'b11
   } bus_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ISS_START,
      ST_WT_START,
      ST_ISS_ADDR,
      ST_WT_ADDR,
      ST_ISS_READ,
      ST_WT_READ,
      ST_ISS_STOP,
      ST_WT_STOP
   } probe_st_e;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
   import scan_pkg::*;
#(
   parameter int FIRST_ADDR = 0,
   parameter int LAST_ADDR  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   output logic [BYTE_W-1:0] addr_o,
   output logic              last_o
);
   localparam logic [BYTE_W-1:0] FIRST_B = BYTE_W'(FIRST_ADDR);
   localparam logic [BYTE_W-1:0] LAST_B  = BYTE_W'(LAST_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_o <= FIRST_B;
      else if (load_i)
         addr_o <= FIRST_B;
      else if (step_i)
         addr_o <= addr_o + 1'b1;
   end

   assign last_o = (addr_o == LAST_B);
endmodule

// File: rtl/scan_probe_fsm.sv
module scan_probe_fsm
   import scan_pkg::*;
#(
   parameter bit READ_FLUSH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [BYTE_W-1:0] addr_i,
   input  logic              last_i,
   input  logic              rsp_valid_i,
   input  logic              rsp_ack_i,
   output logic              cmd_valid_o,
   output logic [1:0]        cmd_op_o,
   output logic              busy_o,
   output logic              hit_o,
   output logic              step_o,
   output logic              fin_o
);
   probe_st_e state_q, state_d;
   logic      flush_req;

   generate
      if (READ_FLUSH) begin : g_flush
         assign flush_req = rsp_ack_i & addr_i[0];
      end else begin : g_no_flush
         assign flush_req = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (go_i) state_d = ST_ISS_START;
         ST_ISS_START: state_d = ST_WT_START;
         ST_WT_START:  if (rsp_valid_i) state_d = ST_ISS_ADDR;
         ST_ISS_ADDR:  state_d = ST_WT_ADDR;
         ST_WT_ADDR:   if (rsp_valid_i) state_d = flush_req ? ST_ISS_READ : ST_ISS_STOP;
         ST_ISS_READ:  state_d = ST_WT_READ;
         ST_WT_READ:   if (rsp_valid_i) state_d = ST_ISS_STOP;
         ST_ISS_STOP:  state_d = ST_WT_STOP;
         ST_WT_STOP:   if (rsp_valid_i) state_d = last_i ? ST_IDLE : ST_ISS_START;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      cmd_valid_o = 1'b1;
      cmd_op_o    = OP_START;
      unique case (state_q)
         ST_ISS_START: cmd_op_o = OP_START;
         ST_ISS_ADDR:  cmd_op_o = OP_WRITE;
         ST_ISS_READ:  cmd_op_o = OP_READ_NACK;
         ST_ISS_STOP:  cmd_op_o = OP_STOP;
         default:      cmd_valid_o = 1'b0;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);
   assign hit_o  = (state_q == ST_WT_ADDR) && rsp_valid_i && rsp_ack_i;
   assign step_o = (state_q == ST_WT_STOP) && rsp_valid_i && !last_i;
   assign fin_o  = (state_q == ST_WT_STOP) && rsp_valid_i && last_i;
endmodule

// File: rtl/i2c_addr_scanner.sv
module i2c_addr_scanner
   import scan_pkg::*;
#(
   parameter int FIRST_ADDR = 0,
   parameter int LAST_ADDR  = 255,
   parameter bit READ_FLUSH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output logic       busy_o,
   output logic       cmd_valid_o,
   output logic [1:0] cmd_op_o,
   output logic [7:0] cmd_byte_o,
   input  logic       rsp_valid_i,
   input  logic       rsp_ack_i,
   output logic       found_valid_o,
   output logic [7:0] found_addr_o,
   output logic       done_o
);
   localparam int ADDR_MAX = (1 << BYTE_W) - 1;

   initial begin
      assert (FIRST_ADDR >= 0 && FIRST_ADDR <= ADDR_MAX)
         else $error("FIRST_ADDR outside raw byte range");
      assert (LAST_ADDR >= FIRST_ADDR && LAST_ADDR <= ADDR_MAX)
         else $error("LAST_ADDR must lie between FIRST_ADDR and the top byte value");
   end

   logic              go, busy, hit, step, fin, last;
   logic [BYTE_W-1:0] addr;

   assign go = start_i & ~busy;

   scan_addr_gen #(
      .FIRST_ADDR(FIRST_ADDR),
      .LAST_ADDR (LAST_ADDR)
   ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(go),
      .step_i(step),
      .addr_o(addr),
      .last_o(last)
   );

   scan_probe_fsm #(
      .READ_FLUSH(READ_FLUSH)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .addr_i     (addr),
      .last_i     (last),
      .rsp_valid_i(rsp_valid_i),
      .rsp_ack_i  (rsp_ack_i),
      .cmd_valid_o(cmd_valid_o),
      .cmd_op_o   (cmd_op_o),
      .busy_o     (busy),
      .hit_o      (hit),
      .step_o     (step),
      .fin_o      (fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_valid_o <= 1'b0;
         found_addr_o  <= '0;
         done_o        <= 1'b0;
      end else begin
         found_valid_o <= hit;
         done_o        <= fin;
         if (hit) found_addr_o <= addr;
      end
   end

   assign busy_o     = busy;
   assign cmd_byte_o = addr;
endmodule

// File: rtl/i2c_addr_scanner_chk.sv
module i2c_addr_scanner_chk
   import scan_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic       cmd_valid_o,
   input logic [1:0] cmd_op_o,
   input logic       rsp_valid_i,
   input logic       found_valid_o,
   input logic       done_o
);
   logic       outstanding;
   logic [1:0] last_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         last_op     <= OP_STOP;
      end else if (cmd_valid_o) begin
         outstanding <= 1'b1;
         last_op     <= cmd_op_o;
      end else if (rsp_valid_i) begin
         outstanding <= 1'b0;
      end
   end

   a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> !outstanding);
   a_r10_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> busy_o);
   a_r2_write_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o == OP_WRITE) |-> last_op == OP_START);
   a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o == OP_READ_NACK) |-> last_op == OP_WRITE);
   a_r5_start_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o == OP_START) |-> last_op == OP_STOP);
   a_r6_found_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      found_valid_o |=> !found_valid_o);
   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

bind i2c_addr_scanner i2c_addr_scanner_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .cmd_valid_o  (cmd_valid_o),
   .cmd_op_o     (cmd_op_o),
   .rsp_valid_i  (rsp_valid_i),
   .found_valid_o(found_valid_o),
   .done_o       (done_o)
);

// File: tb/i2c_addr_scanner_bench.sv
`timescale 1ns/1ps
module i2c_addr_scanner_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       busy_o, cmd_valid_o, found_valid_o, done_o;
   logic [1:0] cmd_op_o;
   logic [7:0] cmd_byte_o, found_addr_o;
   logic       rsp_valid_i = 1'b0;
   logic       rsp_ack_i = 1'b0;

   always #2 clk = ~clk;

   i2c_addr_scanner u_i2c_addr_scanner (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
      .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o),
      .rsp_valid_i(rsp_valid_i), .rsp_ack_i(rsp_ack_i),
      .found_valid_o(found_valid_o), .found_addr_o(found_addr_o), .done_o(done_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit present [256];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int next_hit(input int from);
      for (int a = from; a < 256; a++) if (present[a]) return a;
      return -1;
   endfunction

   function automatic int hit_total();
      int n = 0;
      for (int a = 0; a < 256; a++) if (present[a]) n++;
      return n;
   endfunction

   // bus master and slave model
   int        wait_cnt = 0;
   logic [1:0] pend_op;
   logic [7:0] pend_byte;
   bit        talking = 1'b0;

   always @(negedge clk) begin
      if (rsp_valid_i) begin
         rsp_valid_i <= 1'b0;
         rsp_ack_i   <= 1'b0;
      end
      if (wait_cnt > 0) begin
         wait_cnt--;
         if (wait_cnt == 0) begin
            rsp_valid_i <= 1'b1;
            if (pend_op == 2'b01) begin
               if (talking) rsp_ack_i <= 1'b1;
               else begin
                  rsp_ack_i <= present[pend_byte];
                  if (present[pend_byte] && pend_byte[0]) talking = 1'b1;
               end
            end else if (pend_op == 2'b10) begin
               talking = 1'b0;
            end
         end
      end
      if (cmd_valid_o && rst_n) begin
         pend_op   = cmd_op_o;
         pend_byte = cmd_byte_o;
         wait_cnt  = 1 + int'($urandom % 4);
      end
   end

   // monitor
   int exp_addr = 0;
   int exp_phase = 4;
   int last_hit = -1;
   int hit_idx = 0;
   int done_cnt = 0;
   int scan_no = 0;
   int hits [2][256];
   bit prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid_o) begin
            case (exp_phase)
               0: begin
                  check(cmd_op_o == 2'b00, "R2 START opens probe", cmd_op_o, 0);
                  exp_phase = 1;
               end
               1: begin
                  check(cmd_op_o == 2'b01, "R2 WRITE after START", cmd_op_o, 1);
                  check(cmd_byte_o == 8'(exp_addr), "R3 ascending address", cmd_byte_o, exp_addr);
                  exp_phase = (present[exp_addr] && exp_addr[0]) ? 2 : 3;
               end
               2: begin
                  check(cmd_op_o == 2'b10, "R4 dummy READ after read hit", cmd_op_o, 2);
                  exp_phase = 3;
               end
               3: begin
                  check(cmd_op_o == 2'b11, "R4/R5 STOP ends probe", cmd_op_o, 3);
                  if (exp_addr == 255) exp_phase = 4;
                  else begin
                     exp_addr++;
                     exp_phase = 0;
                  end
               end
               default: check(1'b0, "R7 command after scan end", cmd_op_o, 0);
            endcase
         end
         if (found_valid_o) begin
            int e;
            e = next_hit(last_hit + 1);
            check(int'(found_addr_o) == e, "R6 found address", found_addr_o, e);
            if (hit_idx < 256 && scan_no < 2) hits[scan_no][hit_idx] = int'(found_addr_o);
            last_hit = int'(found_addr_o);
            hit_idx++;
         end
         if (done_o) begin
            check(!busy_o, "R7 busy low with done", busy_o, 0);
            check(exp_phase == 4, "R7 done after last STOP", exp_phase, 4);
            check(hit_idx == hit_total(), "R6 hit count", hit_idx, hit_total());
            check(!prev_done, "R7 done one cycle", 1, 0);
            done_cnt++;
         end
         prev_done = done_o;
      end
   end

   task automatic begin_scan();
      exp_addr  = 0;
      exp_phase = 0;
      last_hit  = -1;
      hit_idx   = 0;
      start_i   = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n1;
      void'($urandom(32'h1c2a5));
      for (int d = 1; d < 127; d++) begin
         int r;
         r = int'($urandom % 8);
         if (d == 8'h68) continue;
         present[2*d]   = (r == 0) || (r == 1);
         present[2*d+1] = (r == 1) || (r == 2);
      end
      present[8'h00] = 1'b1; present[8'h01] = 1'b0;
      present[8'hD0] = 1'b1; present[8'hD1] = 1'b1;
      present[8'hFE] = 1'b1; present[8'hFF] = 1'b1;

      repeat (4) @(negedge clk);
      check(!busy_o && !cmd_valid_o, "R1 reset busy/cmd", {busy_o, cmd_valid_o}, 0);
      check(!found_valid_o && !done_o, "R1 reset found/done", {found_valid_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy_o && !cmd_valid_o && !done_o, "R1 idle after reset", busy_o, 0);

      scan_no = 0;
      begin_scan();
      check(busy_o, "R8 busy during scan", busy_o, 1);
      repeat (300) @(negedge clk);
      start_i = 1'b1;                       // R8: must be ignored
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R8 scan continues", busy_o, 1);
      while (done_cnt < 1) @(negedge clk);
      n1 = hit_idx;
      repeat (10) @(negedge clk);
      check(done_cnt == 1, "R8 single done for scan", done_cnt, 1);
      check(!busy_o, "R7 idle after done", busy_o, 0);

      scan_no = 1;
      begin_scan();
      while (done_cnt < 2) @(negedge clk);
      repeat (5) @(negedge clk);
      check(hit_idx == n1, "R9 repeat scan count", hit_idx, n1);
      for (int i = 0; i < n1 && i < 256; i++)
         check(hits[0][i] == hits[1][i], "R9 repeat scan entry", hits[1][i], hits[0][i]);
      check(hits[0][0] == 8'h00, "R4 write-only first hit", hits[0][0], 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule